// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host a way into a large internal register space through four 32-bit host-visible words. The host places the target address, and for a store the data word as well, in the window. It then writes a command word that asks for either a load or a store. The bridge performs exactly one transfer on an internal request/acknowledge bus. When the transfer finishes, it raises an acknowledge flag in the command word.

The acknowledge flag stays up, and the bridge accepts no new command, until the host writes a zero command. The bridge then returns the command word to zero within one cycle. The host can therefore poll for the acknowledge flag and then poll for zero. Load data stays in a host-readable register until a later load replaces it. A cycle counter bounds each internal transfer. If the target never answers, the bridge abandons the transfer, flags a timeout and still raises the acknowledge flag, so the host's polling loop ends.

Top module: `ibr_bridge`

## Requirements
- R1: After reset, all four host words read zero and the internal request `m_req` is low.
- R2: Host word index 1 holds the target address and index 0 is the command word; bit 0 requests a load and bit 1 requests a store. A load command written in idle makes one internal read of the held address, with `m_we` low. When it is acknowledged, the command word reads 0x5 (load bit plus acknowledge bit 2), and host word index 2 returns the value carried by `m_rdata` with the acknowledge.
- R3: Host word index 3 holds the store data. A store command written in idle makes one internal write, with `m_we` high, of that data to the held address. When it is acknowledged, the command word reads 0x6.
- R4: Writing a command whose bits 1:0 are zero while the acknowledge flag is up returns the command word to 0 on the next cycle. After that, a new command is accepted.
- R5: A command write with bit 0 or bit 1 set, arriving while a transfer is pending or awaiting its clear, starts no transfer and changes nothing else. It sets a sticky error flag at command bit 3, which only a zero command clears.
- R6: A command with both bit 0 and bit 1 set in idle starts no internal transfer and sets the error flag at bit 3.
- R7: Host word index 2 is read-only. It changes only when a load completes with an acknowledge; stores, timeouts and host writes to it leave it unchanged.
- R8: If no acknowledge arrives within TIMEOUT_CYC cycles of the request, the request drops. The command word then shows the acknowledge bit 2 and the timeout flag at bit 4 (0x15 for a load).
- R9: While `m_req` is high, `m_addr`, `m_we` and `m_wdata` stay stable at the values latched when the command was accepted, even if the host rewrites the address or data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_sel | input | 1 | Host access strobe |
| h_wen | input | 1 | Host write enable (with h_sel) |
| h_word | input | 2 | Host word index (byte offset divided by 4) |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data for the selected word |
| m_req | output | 1 | Internal request, held until acknowledge or timeout |
| m_we | output | 1 | Internal write select |
| m_addr | output | AW | Internal address |
| m_wdata | output | DW | Internal write data |
| m_ack | input | 1 | Single-cycle internal acknowledge |
| m_rdata | input | DW | Internal read data, valid with m_ack |

## Verification
The hardest situations to reach are a command that collides with a transfer still in flight, and a target that never answers. The bench's register model has a settable response latency. A long latency keeps the bridge busy while a second command is written, which exercises the error path. A latency far above the timeout limit forces the abandonment path. The bench samples the command word on the exact cycles before and after the limit expires. The main sweep stores to and loads from every model location at four latencies, and it compares each result with a pattern computed from the address and the latency.

// File: rtl/ibr_pkg.sv
// Package: shared state type, command bit positions and host word indices
// for the indirect register access bridge.
package ibr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } ibr_state_t;

    localparam int BIT_LOAD  = 0;
    localparam int BIT_STORE = 1;
    localparam int BIT_ACK   = 2;
    localparam int BIT_ERR   = 3;
    localparam int BIT_TMO   = 4;

    localparam logic [1:0] WORD_CMD  = 2'd0;
    localparam logic [1:0] WORD_ADDR = 2'd1;
    localparam logic [1:0] WORD_RDAT = 2'd2;
    localparam logic [1:0] WORD_WDAT = 2'd3;
endpackage

// File: rtl/ibr_window.sv
// Module: ibr_window
// Host register window. It holds the address and store-data words,
// returns the selected word combinationally, and emits a one-cycle
// strobe with the low command bits whenever the host writes the command word.
// Assumes AW <= DW and DW >= 5.
module ibr_window
    import ibr_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_sel,
    input  logic          h_wen,
    input  logic [1:0]    h_word,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic [DW-1:0] cmd_view,
    input  logic [DW-1:0] rdat_q,
    output logic          cmd_wr,
    output logic [1:0]    cmd_bits,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdat_q
);
    logic host_wr;

    // Decode a host write strobe.
    assign host_wr  = h_sel && h_wen;
    assign cmd_wr   = host_wr && (h_word == WORD_CMD);
    assign cmd_bits = h_wdata[1:0];

    // Store the address and store-data words on host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wdat_q <= '0;
        end else if (host_wr) begin
            if (h_word == WORD_ADDR) addr_q <= AW'(h_wdata);
            if (h_word == WORD_WDAT) wdat_q <= h_wdata;
        end
    end

    // Return the selected host word.
    always_comb begin
        unique case (h_word)
            WORD_CMD:  h_rdata = cmd_view;
            WORD_ADDR: h_rdata = DW'(addr_q);
            WORD_RDAT: h_rdata = rdat_q;
            default:   h_rdata = wdat_q;
        endcase
    end
endmodule

// File: rtl/ibr_master.sv
// Module: ibr_master
// Internal bus master. A start pulse latches the kind, address and data of
// the transfer and raises the request. The request is held until one
// acknowledge or until TIMEOUT_CYC cycles elapse. Assumes TIMEOUT_CYC >= 2,
// and that an acknowledge seen while no request is open is ignored.
module ibr_master #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    output logic          done,
    output logic          fail
);
    localparam int            CW    = $clog2(TIMEOUT_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Completion and abandonment events of the open request.
    assign done = m_req && m_ack;
    assign fail = m_req && !m_ack && (cnt_q == LIMIT);

    // Request register, latched transfer fields and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_req   <= 1'b0;
            m_we    <= 1'b0;
            m_addr  <= '0;
            m_wdata <= '0;
            cnt_q   <= '0;
        end else if (start) begin
            m_req   <= 1'b1;
            m_we    <= start_we;
            m_addr  <= start_addr;
            m_wdata <= start_wdata;
            cnt_q   <= '0;
        end else if (m_req) begin
            if (done || fail) m_req <= 1'b0;
            else              cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ibr_ctrl.sv
// Module: ibr_ctrl
// Command state machine. It accepts a single load or store only in idle,
// tracks the acknowledge, error and timeout flags, captures load data, and
// returns to idle on a zero command once the acknowledge is up.
module ibr_ctrl
    import ibr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [1:0]    cmd_bits,
    input  logic          done,
    input  logic          fail,
    input  logic [DW-1:0] m_rdata,
    output logic          start,
    output logic          start_we,
    output logic [DW-1:0] cmd_view,
    output logic [DW-1:0] rdat_q,
    output ibr_state_t    state
);
    logic [1:0] kind_q;
    logic       ack_q, err_q, tmo_q;
    logic       single, nonzero;

    // Classify the incoming command bits.
    assign single   = cmd_bits[BIT_LOAD] ^ cmd_bits[BIT_STORE];
    assign nonzero  = |cmd_bits;
    assign start    = (state == ST_IDLE) && cmd_wr && single;
    assign start_we = cmd_bits[BIT_STORE];

    // Host view of the command word.
    assign cmd_view = {{(DW-5){1'b0}}, tmo_q, err_q, ack_q, kind_q};

    // State, flags and load-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= 2'b00;
            ack_q  <= 1'b0;
            err_q  <= 1'b0;
            tmo_q  <= 1'b0;
            rdat_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_wr) begin
                        if (single) begin
                            state  <= ST_BUSY;
                            kind_q <= cmd_bits;
                        end else if (nonzero) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q <= 1'b0;
                            tmo_q <= 1'b0;
                        end
                    end
                end
                ST_BUSY: begin
                    if (cmd_wr && nonzero) err_q <= 1'b1;
                    if (done) begin
                        state <= ST_DONE;
                        ack_q <= 1'b1;
                        if (kind_q[BIT_LOAD]) rdat_q <= m_rdata;
                    end else if (fail) begin
                        state <= ST_DONE;
                        ack_q <= 1'b1;
                        tmo_q <= 1'b1;
                    end
                end
                default: begin
                    if (cmd_wr) begin
                        if (nonzero) begin
                            err_q <= 1'b1;
                        end else begin
                            state  <= ST_IDLE;
                            kind_q <= 2'b00;
                            ack_q  <= 1'b0;
                            err_q  <= 1'b0;
                            tmo_q  <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ibr_bridge.sv
// Module: ibr_bridge
// Top of the indirect register access bridge: host window, command state
// machine and internal bus master. Assumes AW <= DW and TIMEOUT_CYC >= 2.
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_sel,
    input  logic          h_wen,
    input  logic [1:0]    h_word,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic [DW-1:0] m_rdata
);
    logic          cmd_wr, start, start_we, done, fail, idle;
    logic [1:0]    cmd_bits;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdat_q, cmd_view, rdat_q;
    ibr_state_t    state;

    // Idle indication for the checker.
    assign idle = (state == ST_IDLE);

    ibr_window #(.AW(AW), .DW(DW)) u_win (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wen(h_wen),
        .h_word(h_word), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .cmd_view(cmd_view), .rdat_q(rdat_q), .cmd_wr(cmd_wr),
        .cmd_bits(cmd_bits), .addr_q(addr_q), .wdat_q(wdat_q)
    );

    ibr_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bits(cmd_bits),
        .done(done), .fail(fail), .m_rdata(m_rdata), .start(start),
        .start_we(start_we), .cmd_view(cmd_view), .rdat_q(rdat_q),
        .state(state)
    );

    ibr_master #(.AW(AW), .DW(DW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_mst (
        .clk(clk), .rst_n(rst_n), .start(start), .start_we(start_we),
        .start_addr(addr_q), .start_wdata(wdat_q), .m_req(m_req),
        .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack),
        .done(done), .fail(fail)
    );
endmodule

// File: rtl/ibr_checker.sv
// Module: ibr_checker
// Temporal properties of the bridge, bound to ibr_bridge.
module ibr_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_sel,
    input logic          h_wen,
    input logic [1:0]    h_word,
    input logic [DW-1:0] h_wdata,
    input logic          m_req,
    input logic          m_we,
    input logic [AW-1:0] m_addr,
    input logic [DW-1:0] m_wdata,
    input logic          m_ack,
    input logic          fail,
    input logic          idle,
    input logic [DW-1:0] cmd_view,
    input logic [DW-1:0] rdat_q
);
    logic hcmd;
    assign hcmd = h_sel && h_wen && (h_word == 2'd0);

    // R9: open request fields stay put until acknowledge or timeout
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack && !fail) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

    // R2: an acknowledge closes the request and raises the host flag
    assert_ack_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack) |=> (!m_req && cmd_view[2]));

    // R6: both command bits in idle start nothing and flag an error
    assert_both_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && hcmd && h_wdata[1:0] == 2'b11) |=> (!m_req && cmd_view[3]));

    // R5: a command while not idle flags an error
    assert_busy_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && hcmd && h_wdata[1:0] != 2'b00) |=> cmd_view[3]);

    // R4: a zero command after acknowledge returns to idle
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_view[2] && hcmd && h_wdata[1:0] == 2'b00) |=> (idle && cmd_view == '0));

    // R7: load data changes only on a load acknowledge
    assert_rdat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_req && m_ack && !m_we) |=> $stable(rdat_q));

    // R8: a timeout drops the request and shows acknowledge and timeout
    assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (!m_req && cmd_view[2] && cmd_view[4]));
endmodule

bind ibr_bridge ibr_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wen(h_wen), .h_word(h_word),
    .h_wdata(h_wdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ack(m_ack), .fail(fail), .idle(idle),
    .cmd_view(cmd_view), .rdat_q(rdat_q)
);

// File: tb/sim_ibr_bridge.sv
// Bench for ibr_bridge: sweeps loads and stores over a 16-word register
// model at several latencies, then drives the collision, dual-command and
// timeout cases.
module sim_ibr_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_sel = 1'b0, h_wen = 1'b0;
    logic [1:0]  h_word = 2'd0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;

    logic [31:0] mem [16];
    int          lat = 0;
    int          wcnt = 0;
    int          acc = 0;
    int          total = 0, bad = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibr_bridge #(.AW(32), .DW(32), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wen(h_wen),
        .h_word(h_word), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_rdata(m_rdata)
    );

    // Internal register model with settable latency.
    always @(posedge clk) begin
        m_ack <= 1'b0;
        if (m_req && !m_ack) begin
            if (wcnt >= lat) begin
                m_ack   <= 1'b1;
                m_rdata <= mem[m_addr[5:2]];
                if (m_we) mem[m_addr[5:2]] <= m_wdata;
                acc  <= acc + 1;
                wcnt <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            wcnt <= 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        h_sel = 1'b1; h_wen = 1'b1; h_word = w; h_wdata = d;
        @(negedge clk);
        h_sel = 1'b0; h_wen = 1'b0;
    endtask

    task automatic peek(input logic [1:0] w, output logic [31:0] d);
        h_word = w;
        #1;
        d = h_rdata;
    endtask

    task automatic hrd(input logic [1:0] w, output logic [31:0] d);
        @(negedge clk);
        peek(w, d);
    endtask

    task automatic poll_ack(output logic [31:0] d);
        int n = 0;
        do begin
            hrd(2'd0, d);
            n++;
        end while (!d[2] && n < 60);
    endtask

    function automatic logic [31:0] pat(input int idx, input int l);
        return 32'hA500_0000 ^ (idx << 8) ^ (l * 32'h1111);
    endfunction

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, last_rd, a;
        int a0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int w = 0; w < 4; w++) begin
            hrd(2'(w), d);
            chk(d == 0, "R1 word after reset", d, 0);
        end
        chk(m_req == 0, "R1 m_req after reset", {31'd0, m_req}, 0);
        last_rd = '0;

        // R2 R3 R4 R7 R9: sweep of stores and loads
        for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int i = 0; i < 16; i++) begin
                a = 32'h0000_1000 + i * 4;
                a0 = acc;
                hwr(2'd3, pat(i, l));
                hwr(2'd1, a);
                hwr(2'd0, 32'h2);
                chk(m_req && m_we && m_addr == a && m_wdata == pat(i, l),
                    "R9 store fields", m_addr, a);
                if (l == 3) begin
                    hwr(2'd1, 32'hFFFF_FFF0);
                    chk(m_req && m_addr == a, "R9 fields held", m_addr, a);
                end
                poll_ack(d);
                chk(d == 32'h6, "R3 store ack word", d, 32'h6);
                chk(mem[i] == pat(i, l), "R3 stored value", mem[i], pat(i, l));
                chk(acc == a0 + 1, "R3 one access", acc, a0 + 1);
                hrd(2'd2, d);
                chk(d == last_rd, "R7 store keeps load data", d, last_rd);
                hwr(2'd0, 32'h0);
                peek(2'd0, d);
                chk(d == 0, "R4 clear after store", d, 0);

                hwr(2'd1, a);
                hwr(2'd0, 32'h1);
                chk(m_req && !m_we && m_addr == a, "R2 load fields", m_addr, a);
                poll_ack(d);
                chk(d == 32'h5, "R2 load ack word", d, 32'h5);
                hrd(2'd2, d);
                chk(d == pat(i, l), "R2 load data", d, pat(i, l));
                last_rd = d;
                hwr(2'd0, 32'h0);
                peek(2'd0, d);
                chk(d == 0, "R4 clear after load", d, 0);
            end
        end

        // R7: host write to the load-data word is ignored
        hwr(2'd2, 32'hDEAD_BEEF);
        hrd(2'd2, d);
        chk(d == last_rd, "R7 load data read-only", d, last_rd);

        // R5: command during a pending transfer and during acknowledge
        lat = 5;
        a0 = acc;
        hwr(2'd1, 32'h0000_1008);
        hwr(2'd0, 32'h1);
        hwr(2'd0, 32'h2);
        poll_ack(d);
        chk(d == 32'hD, "R5 error with ack", d, 32'hD);
        chk(acc == a0 + 1, "R5 collision ignored", acc, a0 + 1);
        hrd(2'd2, d);
        chk(d == mem[2], "R5 load unaffected", d, mem[2]);
        last_rd = d;
        hwr(2'd0, 32'h1);
        repeat (8) @(negedge clk);
        peek(2'd0, d);
        chk(d == 32'hD && acc == a0 + 1, "R5 command in ack state ignored", d, 32'hD);
        hwr(2'd0, 32'h0);
        peek(2'd0, d);
        chk(d == 0, "R5 error cleared by zero command", d, 0);

        // R6: both command bits set in idle
        a0 = acc;
        hwr(2'd0, 32'h3);
        peek(2'd0, d);
        chk(d == 32'h8, "R6 dual command error", d, 32'h8);
        chk(m_req == 0, "R6 no request", {31'd0, m_req}, 0);
        repeat (10) @(negedge clk);
        chk(acc == a0, "R6 no access", acc, a0);
        hwr(2'd0, 32'h0);
        peek(2'd0, d);
        chk(d == 0, "R6 cleared", d, 0);

        // R8: target never answers
        lat = 100000;
        hwr(2'd1, 32'h0000_1004);
        hwr(2'd0, 32'h1);
        repeat (TMO - 1) @(negedge clk);
        peek(2'd0, d);
        chk(d == 32'h1 && m_req, "R8 still pending before limit", d, 32'h1);
        @(negedge clk);
        peek(2'd0, d);
        chk(d == 32'h15, "R8 timeout word", d, 32'h15);
        chk(m_req == 0, "R8 request dropped", {31'd0, m_req}, 0);
        hrd(2'd2, d);
        chk(d == last_rd, "R7 timeout keeps load data", d, last_rd);
        hwr(2'd0, 32'h0);
        peek(2'd0, d);
        chk(d == 0, "R4 clear after timeout", d, 0);

        // R4: a new command is accepted after the clear
        lat = 1;
        hwr(2'd1, 32'h0000_1010);
        hwr(2'd0, 32'h1);
        poll_ack(d);
        chk(d == 32'h5, "R4 accepted after clear", d, 32'h5);
        hrd(2'd2, d);
        chk(d == mem[4], "R2 load after timeout", d, mem[4]);
        hwr(2'd0, 32'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule